// File: doc/BRIEF.md
# Edge-Triggered Wakeup Interrupt Controller

This block gathers interrupt sources for a small controller core. It has eight port pins, each with its own enable bit and its own edge-polarity bit, and one timer-overflow source. A chosen edge on a pin always sets that pin's pending bit. A request reaches the core only when the pin is enabled. The enable bits are active-low. The timer source has no pending bit. It raises a request only in the cycle that the rollover pulse arrives, and only while its enable input is high. No source has priority over another, and the core's service routine reads the pending register to find out which pin fired.

When the core accepts a request, all further requests are masked until the return instruction. In that same cycle the block copies the core's program counter, working register, status register and pointer register into one level of shadow storage. In the following cycle it sends back the saved status with the page-select bits cleared. When the core returns, the shadow contents come back out for one cycle so the core can restore its state, and requests are unmasked again. A second form of return also hands the core the working register value that it must add to the timer. The vector address is fixed at zero.

The restore and status outputs are single-cycle valid pulses with no ready signal. The core must take them in the cycle they appear, and the block never holds or repeats them. All other pins are plain control levels.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset the enable and edge-select registers both hold all ones, so all pins are disabled and set to the falling edge. `irq`, `stat_wr_valid`, `restore_valid` and `tmr_add_valid` are low. The pending register has no reset value and must be cleared by a write before use.
- R2: Edge-select bit i = 0 sets pending bit i on a rising edge of pin i, and bit i = 1 sets it on a falling edge. The opposite edge leaves the bit unchanged. The bit is visible on `pnd_rd` one clock after the edge is sampled.
- R3: A pending bit is set whatever its enable bit holds. `irq` is driven by the pins only while some pin i has pending bit i = 1 and enable bit i = 0.
- R4: A write to the pending register clears every bit whose written value is 0 and leaves every bit whose written value is 1 unchanged. If a selected edge arrives in the same cycle as a clearing write, the pending bit ends up set.
- R5: A `tmr_roll` pulse raises `irq` combinationally in that same cycle when `tmr_ie` is 1. It has no effect when `tmr_ie` is 0, and it never changes `pnd_rd`.
- R6: An accepted acknowledge (`ack` while `irq` is high) masks `irq` from the next cycle until an accepted return. Edges that arrive while masked stay pending, and `irq` rises again one cycle after the return.
- R7: On an accepted acknowledge, the block captures `cpu_pc`, `cpu_w`, `cpu_status` and `cpu_ptr`. In the next cycle `stat_wr_valid` is high and `stat_wr_data` equals the captured status with bits 7:5 forced to 0.
- R8: One cycle after an accepted return, `restore_valid` is high for one cycle and the four restore outputs carry the values captured at the acknowledge.
- R9: A return with `ret_addw` = 1 also pulses `tmr_add_valid` together with `restore_valid`, and `tmr_add_val` equals `cpu_w` at the return. A plain return leaves `tmr_add_valid` low.
- R10: `vec_addr` is always 0.
- R11: `ack` while `irq` is low is ignored, and produces no `stat_wr_valid`. `ret` while not in service is ignored, and produces no `restore_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 8 | Synchronized pin levels |
| tmr_roll | input | 1 | Timer rollover pulse from FFh to 00h |
| tmr_ie | input | 1 | Timer interrupt enable |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable write data (0 = enabled) |
| edge_we | input | 1 | Edge-select write strobe |
| edge_wdata | input | 8 | Edge-select data (1 = falling) |
| pnd_we | input | 1 | Pending write strobe |
| pnd_wdata | input | 8 | Pending write data (0 clears) |
| ack | input | 1 | Interrupt acknowledge from core |
| ret | input | 1 | Return-from-interrupt strobe |
| ret_addw | input | 1 | Return variant that adds W to the timer |
| cpu_pc | input | 11 | Core program counter |
| cpu_w | input | 8 | Core working register |
| cpu_status | input | 8 | Core status register |
| cpu_ptr | input | 8 | Core pointer register |
| irq | output | 1 | Interrupt request |
| vec_addr | output | 11 | Service vector address |
| pnd_rd | output | 8 | Pending register read-back |
| stat_wr_valid | output | 1 | Status rewrite pulse after acknowledge |
| stat_wr_data | output | 8 | Status with page bits cleared |
| restore_valid | output | 1 | Restore pulse after return |
| rst_pc | output | 11 | Restored program counter |
| rst_w | output | 8 | Restored working register |
| rst_status | output | 8 | Restored status |
| rst_ptr | output | 8 | Restored pointer |
| tmr_add_valid | output | 1 | Add W to timer pulse |
| tmr_add_val | output | 8 | Value to add to the timer |

## Verification
A software write that clears pending bits can land in the same cycle as a new selected edge on one of those pins. The bench provokes this by making pin 3 fall while writing all zeros to the pending register, then requires pin 3's bit to read back set. A second collision is an edge arriving while service is masked. The bench raises a pin and clears another pending bit during service, then judges that `irq` stays low until the return and rises in the cycle after it. A scoreboard queue compares every restore pulse against the state captured at its acknowledge.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  localparam int WORD_W = 8;
  localparam int PC_W   = 11;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [WORD_W-1:0] w;
    logic [WORD_W-1:0] status;
    logic [WORD_W-1:0] ptr;
  } core_ctx_t;
endpackage

// File: rtl/wake_edge_bank.sv
module wake_edge_bank #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic            en_we,
  input  logic [NPIN-1:0] en_wdata,
  input  logic            edge_we,
  input  logic [NPIN-1:0] edge_wdata,
  input  logic            pnd_we,
  input  logic [NPIN-1:0] pnd_wdata,
  output logic [NPIN-1:0] pnd_q,
  output logic            ext_req
);
  logic [NPIN-1:0] en_n_q, fall_sel_q, prev_q, hit;
  logic            armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q     <= '1;
      fall_sel_q <= '1;
      prev_q     <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (en_we)   en_n_q     <= en_wdata;
      if (edge_we) fall_sel_q <= edge_wdata;
      prev_q  <= pin_lvl;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall;
    assign rise   = pin_lvl[i] & ~prev_q[i];
    assign fall   = ~pin_lvl[i] & prev_q[i];
    assign hit[i] = armed_q & (fall_sel_q[i] ? fall : rise);

    // pending bit has no reset: software clears it before enabling
    always_ff @(posedge clk) begin
      if (hit[i])                      pnd_q[i] <= 1'b1;
      else if (pnd_we && !pnd_wdata[i]) pnd_q[i] <= 1'b0;
    end
  end

  assign ext_req = |(pnd_q & ~en_n_q);

  // R4: a cleared bit stays clear unless an edge hit that cycle
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_we |=> ((pnd_q & ~$past(pnd_wdata) & ~$past(hit)) == '0));
  // R2: a hit always leaves the bit set
  a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pnd_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/wake_svc_fsm.sv
module wake_svc_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  input  logic ret,
  output logic in_svc,
  output logic take,
  output logic give
);
  always_comb begin
    take = ack & req & ~in_svc;
    give = ret & in_svc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_svc <= 1'b0;
    else if (take) in_svc <= 1'b1;
    else if (give) in_svc <= 1'b0;
  end

  // R6: service is entered on an accepted acknowledge
  a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_svc);
  // R6: service ends on an accepted return
  a_r6_leave: assert property (@(posedge clk) disable iff (!rst_n)
    give |=> !in_svc);
endmodule

// File: rtl/wake_shadow.sv
module wake_shadow
  import wake_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] PAGE_MASK = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              give,
  input  logic              ret_addw,
  input  core_ctx_t         live,
  output logic              stat_wr_valid,
  output logic [WORD_W-1:0] stat_wr_data,
  output logic              restore_valid,
  output core_ctx_t         saved,
  output logic              tmr_add_valid,
  output logic [WORD_W-1:0] tmr_add_val
);
  core_ctx_t sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q          <= '0;
      stat_wr_valid <= 1'b0;
      restore_valid <= 1'b0;
      tmr_add_valid <= 1'b0;
      tmr_add_val   <= '0;
    end else begin
      if (take) sh_q <= live;
      stat_wr_valid <= take;
      restore_valid <= give;
      tmr_add_valid <= give & ret_addw;
      if (give) tmr_add_val <= live.w;
    end
  end

  assign stat_wr_data = sh_q.status & ~PAGE_MASK;
  assign saved        = sh_q;

  // R7: page bits are never handed back set
  a_r7_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_valid |-> ((stat_wr_data & PAGE_MASK) == '0));
  // R9: timer add only accompanies a restore
  a_r9_add_with_restore: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_add_valid |-> restore_valid);
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int                NPIN      = 8,
  parameter logic [PC_W-1:0]   VEC_ADDR  = '0,
  parameter logic [WORD_W-1:0] PAGE_MASK = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic              tmr_roll,
  input  logic              tmr_ie,
  input  logic              en_we,
  input  logic [NPIN-1:0]   en_wdata,
  input  logic              edge_we,
  input  logic [NPIN-1:0]   edge_wdata,
  input  logic              pnd_we,
  input  logic [NPIN-1:0]   pnd_wdata,
  input  logic              ack,
  input  logic              ret,
  input  logic              ret_addw,
  input  logic [PC_W-1:0]   cpu_pc,
  input  logic [WORD_W-1:0] cpu_w,
  input  logic [WORD_W-1:0] cpu_status,
  input  logic [WORD_W-1:0] cpu_ptr,
  output logic              irq,
  output logic [PC_W-1:0]   vec_addr,
  output logic [NPIN-1:0]   pnd_rd,
  output logic              stat_wr_valid,
  output logic [WORD_W-1:0] stat_wr_data,
  output logic              restore_valid,
  output logic [PC_W-1:0]   rst_pc,
  output logic [WORD_W-1:0] rst_w,
  output logic [WORD_W-1:0] rst_status,
  output logic [WORD_W-1:0] rst_ptr,
  output logic              tmr_add_valid,
  output logic [WORD_W-1:0] tmr_add_val
);
  logic      ext_req, any_req, in_svc, take, give;
  core_ctx_t live, saved;

  wake_edge_bank #(.NPIN(NPIN)) u_bank (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
    .en_we(en_we), .en_wdata(en_wdata),
    .edge_we(edge_we), .edge_wdata(edge_wdata),
    .pnd_we(pnd_we), .pnd_wdata(pnd_wdata),
    .pnd_q(pnd_rd), .ext_req(ext_req)
  );

  assign any_req = ext_req | (tmr_roll & tmr_ie);

  wake_svc_fsm u_svc (
    .clk(clk), .rst_n(rst_n), .req(any_req), .ack(ack), .ret(ret),
    .in_svc(in_svc), .take(take), .give(give)
  );

  assign live = '{pc: cpu_pc, w: cpu_w, status: cpu_status, ptr: cpu_ptr};

  wake_shadow #(.PAGE_MASK(PAGE_MASK)) u_shadow (
    .clk(clk), .rst_n(rst_n), .take(take), .give(give), .ret_addw(ret_addw),
    .live(live), .stat_wr_valid(stat_wr_valid), .stat_wr_data(stat_wr_data),
    .restore_valid(restore_valid), .saved(saved),
    .tmr_add_valid(tmr_add_valid), .tmr_add_val(tmr_add_val)
  );

  assign irq        = any_req & ~in_svc;
  assign vec_addr   = VEC_ADDR;
  assign rst_pc     = saved.pc;
  assign rst_w      = saved.w;
  assign rst_status = saved.status;
  assign rst_ptr    = saved.ptr;

  // R6: an accepted acknowledge masks the request in the next cycle
  a_r6_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !irq);
  // R8: an accepted return yields a restore pulse
  a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && in_svc) |=> restore_valid);
  // R11: a return outside service is ignored
  a_r11_stray_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !in_svc) |=> !restore_valid);
  // R11: an acknowledge without request is ignored
  a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq) |=> !stat_wr_valid);
endmodule

// File: tb/wake_irq_ctrl_tb_top.sv
module wake_irq_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  pin_lvl = 0, en_wdata = 0, edge_wdata = 0, pnd_wdata = 0;
  logic        tmr_roll = 0, tmr_ie = 0, en_we = 0, edge_we = 0, pnd_we = 0;
  logic        ack = 0, ret = 0, ret_addw = 0;
  logic [10:0] cpu_pc = 0;
  logic [7:0]  cpu_w = 0, cpu_status = 0, cpu_ptr = 0;
  logic        irq, stat_wr_valid, restore_valid, tmr_add_valid;
  logic [10:0] vec_addr, rst_pc;
  logic [7:0]  pnd_rd, stat_wr_data, rst_w, rst_status, rst_ptr, tmr_add_val;

  int checks = 0, errors = 0;
  logic [34:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  wake_irq_ctrl dut_i (.*);

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    en_we = 0; edge_we = 0; pnd_we = 0; ack = 0; ret = 0; ret_addw = 0; tmr_roll = 0;
  endtask

  // driver side of the scoreboard: acknowledge and record expected restore
  task automatic do_ack(logic [10:0] pc, logic [7:0] w, logic [7:0] st, logic [7:0] p);
    cpu_pc = pc; cpu_w = w; cpu_status = st; cpu_ptr = p; ack = 1;
    exp_q.push_back({pc, w, st, p});
    tick();
  endtask

  // monitor side: compare each restore pulse with the queued expectation
  always @(negedge clk) begin
    if (rst_n && restore_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 actual unexpected restore expected none");
      end else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        if ({rst_pc, rst_w, rst_status, rst_ptr} !== e) begin
          errors++;
          $display("FAIL R8 actual %0h expected %0h", {rst_pc, rst_w, rst_status, rst_ptr}, e);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual timeout expected finish");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 valids", {stat_wr_valid, restore_valid, tmr_add_valid}, 0);
    chk("R10 vec", vec_addr, 0);
    pnd_we = 1; pnd_wdata = 8'h00; tick();
    chk("R4 clear all", pnd_rd, 0);
    // R1: falling edge selected, pins disabled
    pin_lvl = 8'h01; tick();
    chk("R1 rise ignored by default edge", pnd_rd, 0);
    pin_lvl = 8'h00; tick();
    chk("R1 fall sets pending", pnd_rd, 8'h01);
    chk("R1 disabled no irq", irq, 0);
    pnd_we = 1; pnd_wdata = 8'h00; tick();
    // R2/R3 rising edges, pin0 enabled only
    edge_we = 1; edge_wdata = 8'h00; en_we = 1; en_wdata = 8'hFE; tick();
    pin_lvl = 8'h02; tick();
    chk("R3 pending while disabled", pnd_rd, 8'h02);
    chk("R3 disabled pin no irq", irq, 0);
    pin_lvl = 8'h03; tick();
    chk("R2 rising edge pending", pnd_rd, 8'h03);
    chk("R3 enabled pin irq", irq, 1);
    pin_lvl = 8'h02; tick();
    chk("R2 falling ignored when rising selected", pnd_rd, 8'h03);
    pnd_we = 1; pnd_wdata = 8'hFD; tick();
    chk("R4 write one keeps write zero clears", pnd_rd, 8'h01);
    // R6/R7 acknowledge
    do_ack(11'h2AB, 8'h11, 8'hFF, 8'h93);
    chk("R6 masked after ack", irq, 0);
    chk("R7 status pulse", {stat_wr_valid, stat_wr_data}, {1'b1, 8'h1F});
    en_we = 1; en_wdata = 8'hFA; pin_lvl = 8'h06; tick();
    pnd_we = 1; pnd_wdata = 8'hFE; tick();
    chk("R6 edge pending while masked", pnd_rd, 8'h04);
    chk("R6 still masked", irq, 0);
    cpu_w = 8'h40; ret = 1; ret_addw = 1; tick();
    chk("R9 add pulse", {tmr_add_valid, tmr_add_val}, {1'b1, 8'h40});
    chk("R6 irq after return", irq, 1);
    do_ack(11'h155, 8'h22, 8'hA5, 8'h07);
    chk("R7 status pulse 2", {stat_wr_valid, stat_wr_data}, {1'b1, 8'h05});
    ret = 1; tick();
    chk("R9 plain return no add", tmr_add_valid, 0);
    pnd_we = 1; pnd_wdata = 8'h00; tick();
    // R5 timer
    tmr_roll = 1; tmr_ie = 0; #1;
    chk("R5 roll without enable", irq, 0);
    tick();
    tmr_roll = 1; tmr_ie = 1; #1;
    chk("R5 roll with enable", irq, 1);
    chk("R5 no pending bit", pnd_rd, 0);
    do_ack(11'h7FF, 8'h99, 8'h20, 8'h55);
    chk("R5 timer ack accepted", {stat_wr_valid, stat_wr_data}, {1'b1, 8'h00});
    ret = 1; tick();
    // R11 stray strobes
    ret = 1; tick();
    chk("R11 stray return", restore_valid, 0);
    ack = 1; tick();
    chk("R11 stray ack", stat_wr_valid, 0);
    // R4 collision: edge and clear in one cycle
    edge_we = 1; edge_wdata = 8'h08; pin_lvl = 8'h0E; tick();
    pnd_we = 1; pnd_wdata = 8'h00; tick();
    pin_lvl = 8'h06; pnd_we = 1; pnd_wdata = 8'h00; tick();
    chk("R4 edge beats clear", pnd_rd, 8'h08);
    chk("R10 vec end", vec_addr, 0);
    tick(); tick();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule